// File: doc/BRIEF.md
# Banked Code Window Cache with CPU Stall

This block serves a 1 KB read-only code window for an 8-bit processor. The code image is 8 KB and sits in slow flash that returns one whole 16-byte page per transaction. The processor sees one 1 KB bank of that image at a time. The block keeps a single on-chip copy of the selected bank. Window reads are answered from that copy one clock after they are accepted.

When software selects a bank that is not the one held in the copy, the block fetches it. It issues 64 page reads over a request/acknowledge port and writes each returned page byte by byte into the cache array. For the whole copy it holds the processor's ready line low. A new selection that arrives during a copy abandons that copy and starts again from the first page of the new bank. After reset nothing is cached. The first window read then fetches bank 0 without any explicit selection.

Top module: `bank_rom_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `fl_req` is 0 and `cpu_rdata` is 0. No flash request is made until a window read or a bank select occurs.
- R2: When a window read (`cpu_rd`=1) arrives with no bank cached, `cpu_ready` goes low in that same cycle and bank 0 is fetched. The read then completes with the bank 0 byte at `cpu_addr`.
- R3: During a copy, flash requests are page aligned (`fl_addr[3:0]`=0). The byte address of page p of bank b is b*1024 + p*16, and pages are requested in ascending order from page 0.
- R4: Byte i of the page returned for page p (bits `fl_data[8*i+7:8*i]`) is later read back from window offset p*16 + i.
- R5: A bank select (`bank_wr`=1, bank on `bank_din`) naming a different bank drops `cpu_ready` in the same cycle. `cpu_ready` stays low until the last byte of page 63 is written, which happens after exactly 64 acknowledged pages.
- R6: Selecting the bank that is already cached makes no flash request, and `cpu_ready` stays high.
- R7: A bank select during a copy aborts it. The copy restarts at page 0 of the new bank, and afterwards the whole window holds the new bank.
- R8: A read accepted at a clock edge (`cpu_rd` and `cpu_ready` both 1) presents its byte on `cpu_rdata` after that edge. `cpu_rdata` holds its value in cycles where no read is accepted.
- R9: `fl_req`, once raised, stays high with a stable `fl_addr` until `fl_ack` is seen. Each acknowledged cycle completes one page.
- R10: A page acknowledged for a request issued before an abort is discarded. It is not written to the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_wr | input | 1 | Bank select strobe |
| bank_din | input | 3 | Bank number to map into the window |
| cpu_rd | input | 1 | Window read strobe |
| cpu_addr | input | 10 | Byte offset within the window |
| cpu_rdata | output | 8 | Read data, valid the cycle after acceptance |
| cpu_ready | output | 1 | Processor ready; low stalls the processor |
| fl_req | output | 1 | Flash page read request |
| fl_addr | output | 13 | Flash byte address of the requested page |
| fl_ack | input | 1 | Flash acknowledge, one cycle, with page data |
| fl_data | input | 128 | Returned page, byte i on bits 8*i+7..8*i |

## Verification
The bench goes after the restart cases. In one, a second select lands while a page request is still pending. A design that kept that stale page would leave bytes of the old bank at the start of the window. In another, a select comes in the middle of a copy. A design that resumed at the current page instead of page 0 would leave part of the window unfilled, and a full readback of the bank exposes this. Reselecting the cached bank is checked through the flash request count, which a design that refilled anyway would raise by 64. The first read after reset is checked to stall and to return bank 0 data. A design that served the uninitialised array would return the wrong byte, and one that fetched nothing would never release the stall.

// File: rtl/rom_cache_pkg.sv
package rom_cache_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_state_e;
endpackage

// File: rtl/rom_rst_sync.sv
module rom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rom_page_lane.sv
module rom_page_lane #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int PG_W      = PAGE_BYTES * DATA_W
) (
  input  logic [PG_W-1:0]   page,
  input  logic [PAGE_W-1:0] idx,
  output logic [DATA_W-1:0] lane_byte
);
  logic [DATA_W-1:0] lanes [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    assign lanes[g] = page[g*DATA_W +: DATA_W];
  end

  assign lane_byte = lanes[idx];
endmodule

// File: rtl/rom_cache_mem.sv
module rom_cache_mem #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rom_fill_ctrl.sv
module rom_fill_ctrl
  import rom_cache_pkg::*;
#(
  parameter int BANK_W     = 3,
  parameter int PIDX_W     = 6,
  parameter int PAGE_W     = 4,
  parameter int DATA_W     = 8,
  localparam int FL_AW     = BANK_W + PIDX_W + PAGE_W,
  localparam int PG_W      = (1 << PAGE_W) * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_din,
  input  logic              cpu_rd,
  output logic              cpu_ready,
  output logic              fl_req,
  output logic [FL_AW-1:0]  fl_addr,
  input  logic              fl_ack,
  input  logic [PG_W-1:0]   fl_data,
  output logic              wr_en,
  output logic [PIDX_W-1:0] wr_page,
  output logic [PAGE_W-1:0] wr_idx,
  output logic [PG_W-1:0]   page_buf,
  output logic              valid_o,
  output logic [BANK_W-1:0] bank_o
);
  fill_state_e       state_q, state_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic              valid_q, valid_n;
  logic              stale_q, stale_n;
  logic [PIDX_W-1:0] page_q, page_n;
  logic [PAGE_W-1:0] idx_q, idx_n;
  logic [FL_AW-1:0]  addr_q, addr_n;
  logic [PG_W-1:0]   pbuf_q, pbuf_n;
  logic              start_sel, start_auto;

  // a select restarts unless it names the bank already held and valid
  assign start_sel  = bank_wr && (state_q != FS_IDLE || !valid_q || bank_din != bank_q);
  assign start_auto = cpu_rd && !bank_wr && !valid_q && state_q == FS_IDLE;

  always_comb begin
    state_n = state_q;
    bank_n  = bank_q;
    valid_n = valid_q;
    stale_n = stale_q;
    page_n  = page_q;
    idx_n   = idx_q;
    addr_n  = addr_q;
    pbuf_n  = pbuf_q;
    if (start_sel) begin
      bank_n  = bank_din;
      valid_n = 1'b0;
      page_n  = '0;
      idx_n   = '0;
      if (state_q == FS_REQ && !fl_ack) begin
        // request in flight: keep its address until acknowledged, then drop it
        stale_n = 1'b1;
      end else begin
        state_n = FS_REQ;
        stale_n = 1'b0;
        addr_n  = {bank_din, {PIDX_W{1'b0}}, {PAGE_W{1'b0}}};
      end
    end else if (start_auto) begin
      state_n = FS_REQ;
      stale_n = 1'b0;
      page_n  = '0;
      idx_n   = '0;
      addr_n  = {bank_q, {PIDX_W{1'b0}}, {PAGE_W{1'b0}}};
    end else begin
      unique case (state_q)
        FS_REQ: begin
          if (fl_ack) begin
            if (stale_q) begin
              stale_n = 1'b0;
              addr_n  = {bank_q, page_q, {PAGE_W{1'b0}}};
            end else begin
              pbuf_n  = fl_data;
              idx_n   = '0;
              state_n = FS_FILL;
            end
          end
        end
        FS_FILL: begin
          idx_n = idx_q + 1'b1;
          if (idx_q == {PAGE_W{1'b1}}) begin
            if (page_q == {PIDX_W{1'b1}}) begin
              state_n = FS_IDLE;
              valid_n = 1'b1;
            end else begin
              page_n  = page_q + 1'b1;
              addr_n  = {bank_q, page_q + 1'b1, {PAGE_W{1'b0}}};
              state_n = FS_REQ;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      bank_q  <= '0;
      valid_q <= 1'b0;
      stale_q <= 1'b0;
      page_q  <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      pbuf_q  <= '0;
    end else begin
      state_q <= state_n;
      bank_q  <= bank_n;
      valid_q <= valid_n;
      stale_q <= stale_n;
      page_q  <= page_n;
      idx_q   <= idx_n;
      addr_q  <= addr_n;
      if (state_q == FS_REQ && fl_ack) pbuf_q <= pbuf_n;
    end
  end

  assign cpu_ready = (state_q == FS_IDLE) && !start_sel && !start_auto;
  assign fl_req    = (state_q == FS_REQ);
  assign fl_addr   = addr_q;
  assign wr_en     = (state_q == FS_FILL) && !start_sel;
  assign wr_page   = page_q;
  assign wr_idx    = idx_q;
  assign page_buf  = pbuf_q;
  assign valid_o   = valid_q;
  assign bank_o    = bank_q;
endmodule

// File: rtl/bank_rom_cache.sv
module bank_rom_cache #(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_BYTES = 1024,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int WIN_AW    = $clog2(BANK_BYTES),
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int PIDX_W    = WIN_AW - PAGE_W,
  localparam int FL_AW     = BANK_W + WIN_AW,
  localparam int PG_W      = PAGE_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_din,
  input  logic              cpu_rd,
  input  logic [WIN_AW-1:0] cpu_addr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              fl_req,
  output logic [FL_AW-1:0]  fl_addr,
  input  logic              fl_ack,
  input  logic [PG_W-1:0]   fl_data
);
  logic              rst_core_n;
  logic              wr_en;
  logic [PIDX_W-1:0] wr_page;
  logic [PAGE_W-1:0] wr_idx;
  logic [PG_W-1:0]   page_buf;
  logic [DATA_W-1:0] wr_byte;
  logic              cache_valid;
  logic [BANK_W-1:0] cur_bank;

  rom_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rom_fill_ctrl #(
    .BANK_W (BANK_W),
    .PIDX_W (PIDX_W),
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bank_wr   (bank_wr),
    .bank_din  (bank_din),
    .cpu_rd    (cpu_rd),
    .cpu_ready (cpu_ready),
    .fl_req    (fl_req),
    .fl_addr   (fl_addr),
    .fl_ack    (fl_ack),
    .fl_data   (fl_data),
    .wr_en     (wr_en),
    .wr_page   (wr_page),
    .wr_idx    (wr_idx),
    .page_buf  (page_buf),
    .valid_o   (cache_valid),
    .bank_o    (cur_bank)
  );

  rom_page_lane #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_lane (
    .page      (page_buf),
    .idx       (wr_idx),
    .lane_byte (wr_byte)
  );

  rom_cache_mem #(
    .DEPTH  (BANK_BYTES),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (wr_en),
    .waddr ({wr_page, wr_idx}),
    .wdata (wr_byte),
    .re    (cpu_rd && cpu_ready),
    .raddr (cpu_addr),
    .rdata (cpu_rdata)
  );
endmodule

// File: rtl/rom_cache_chk.sv
module rom_cache_chk #(
  parameter int BANK_W = 3,
  parameter int FL_AW  = 13,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_wr,
  input logic [BANK_W-1:0] bank_din,
  input logic              cpu_rd,
  input logic              cpu_ready,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              fl_req,
  input logic [FL_AW-1:0]  fl_addr,
  input logic              fl_ack,
  input logic              cache_valid,
  input logic [BANK_W-1:0] cur_bank
);
  p_first_read_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !bank_wr && !cache_valid) |-> !cpu_ready);

  p_page_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> (fl_addr[PAGE_W-1:0] == '0));

  p_stall_while_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> !cpu_ready);

  p_switch_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && bank_din != cur_bank) |=> !cpu_ready);

  p_same_bank_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && cpu_ready && cache_valid && bank_din == cur_bank) |=> !fl_req);

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && cpu_ready) |=> $stable(cpu_rdata));

  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr)));
endmodule

bind bank_rom_cache rom_cache_chk #(
  .BANK_W (BANK_W),
  .FL_AW  (FL_AW),
  .PAGE_W (PAGE_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bank_wr     (bank_wr),
  .bank_din    (bank_din),
  .cpu_rd      (cpu_rd),
  .cpu_ready   (cpu_ready),
  .cpu_rdata   (cpu_rdata),
  .fl_req      (fl_req),
  .fl_addr     (fl_addr),
  .fl_ack      (fl_ack),
  .cache_valid (cache_valid),
  .cur_bank    (cur_bank)
);

// File: tb/sim_bank_rom_cache.sv
module sim_bank_rom_cache;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int WDOG       = 150000;
  localparam int NVEC       = 10;
  // {bank[2:0], offset[9:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    13'h0000, 13'h03FF, 13'h0411, 13'h07F0, 13'h0C2A,
    13'h1C05, 13'h1FFF, 13'h1C80, 13'h0A55, 13'h14C3};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bank_wr;
  logic [2:0]   bank_din;
  logic         cpu_rd;
  logic [9:0]   cpu_addr;
  logic [7:0]   cpu_rdata;
  logic         cpu_ready;
  logic         fl_req;
  logic [12:0]  fl_addr;
  logic         fl_ack;
  logic [127:0] fl_data;

  int checks = 0;
  int errors = 0;
  int ack_cnt = 0;
  int seq_err = 0;
  int req_rise = 0;
  logic [12:0] exp_a;
  logic        req_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_rom_cache u0 (
    .clk (clk), .rst_n (rst_n), .bank_wr (bank_wr), .bank_din (bank_din),
    .cpu_rd (cpu_rd), .cpu_addr (cpu_addr), .cpu_rdata (cpu_rdata),
    .cpu_ready (cpu_ready), .fl_req (fl_req), .fl_addr (fl_addr),
    .fl_ack (fl_ack), .fl_data (fl_data));

  function automatic logic [7:0] fdat(int a);
    return 8'((a * 29) ^ (a >> 7) ^ 8'h5A);
  endfunction

  // behavioural flash: acknowledges LAT cycles after a request
  int lat_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ack  <= 1'b0;
      lat_cnt <= 0;
      fl_data <= '0;
    end else if (fl_ack) begin
      fl_ack  <= 1'b0;
      lat_cnt <= 0;
    end else if (fl_req) begin
      if (lat_cnt == LAT - 1) begin
        fl_ack <= 1'b1;
        for (int i = 0; i < 16; i++) fl_data[i*8 +: 8] <= fdat(int'(fl_addr) + i);
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      lat_cnt <= 0;
    end
  end

  // request monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      exp_a <= '0;
    end else begin
      req_d <= fl_req;
      if (fl_req && !req_d) req_rise <= req_rise + 1;
      if (fl_ack) begin
        ack_cnt <= ack_cnt + 1;
        if (fl_addr[3:0] != 4'h0) seq_err <= seq_err + 1;
        else if (fl_addr[9:0] != 10'h0 && fl_addr != exp_a) seq_err <= seq_err + 1;
        exp_a <= fl_addr + 13'd16;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_rd = 1'b1;
    cpu_addr = a;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic sel_bank(input logic [2:0] b, output int acks, output bit was_low);
    int a0;
    @(negedge clk);
    a0 = ack_cnt;
    bank_wr = 1'b1;
    bank_din = b;
    #1 was_low = !cpu_ready;
    @(negedge clk);
    bank_wr = 1'b0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    acks = ack_cnt - a0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WDOG) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int acks, a0, r0, bad;
    bit low;
    logic [2:0] cur;
    rst_n = 1'b0; bank_wr = 1'b0; bank_din = '0; cpu_rd = 1'b0; cpu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and no spontaneous fetch
    check("R1 ready", int'(cpu_ready), 1);
    check("R1 rdata", int'(cpu_rdata), 0);
    repeat (10) @(negedge clk);
    check("R1 no req", req_rise, 0);

    // R2 first read fetches bank 0; R9 64 pages; R3 order
    a0 = ack_cnt;
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 10'h123;
    #1 check("R2 stall", int'(cpu_ready), 0);
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_rd = 1'b0;
    check("R2 data", int'(cpu_rdata), int'(fdat(12'h123)));
    check("R9 page count", ack_cnt - a0, 64);
    check("R3 order", seq_err, 0);
    cur = 3'd0;

    // vector table: R4 data mapping, R5 stall, R6 same bank, R8 latency
    for (int v = 0; v < NVEC; v++) begin
      sel_bank(VEC[v][12:10], acks, low);
      if (VEC[v][12:10] == cur) begin
        check("R6 no refill", acks, 0);
        check("R6 ready kept", int'(low), 0);
      end else begin
        check("R5 pages", acks, 64);
        check("R5 stall", int'(low), 1);
      end
      cur = VEC[v][12:10];
      do_read(VEC[v][9:0], d);
      check("R4 R8 byte", int'(d), int'(fdat(int'(VEC[v]))));
    end

    // R8 rdata held with no read
    d = cpu_rdata;
    repeat (6) @(negedge clk);
    check("R8 hold", int'(cpu_rdata), int'(d));

    // R6 reselect cached bank: no request over a window
    r0 = req_rise;
    sel_bank(cur, acks, low);
    repeat (20) @(negedge clk);
    check("R6 req count", req_rise - r0, 0);

    // R7 abort mid copy: bank 2 then bank 6
    @(negedge clk);
    bank_wr = 1'b1; bank_din = 3'd2;
    @(negedge clk);
    bank_wr = 1'b0;
    repeat (150) @(negedge clk);
    check("R7 still stalled", int'(cpu_ready), 0);
    sel_bank(3'd6, acks, low);
    check("R7 stall", int'(low), 1);
    bad = 0;
    for (int k = 0; k < 1024; k++) begin
      do_read(10'(k), d);
      if (d != fdat(6 * 1024 + k)) bad++;
    end
    check("R7 R4 full bank", bad, 0);
    check("R3 order after abort", seq_err, 0);

    // R10 select while a page request is pending: 3 then 4
    @(negedge clk);
    bank_wr = 1'b1; bank_din = 3'd3;
    @(negedge clk);
    bank_din = 3'd4;
    @(negedge clk);
    bank_wr = 1'b0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      do_read(10'(k), d);
      if (d != fdat(4 * 1024 + k)) bad++;
    end
    check("R10 stale page dropped", bad, 0);
    do_read(10'h3FF, d);
    check("R10 last byte", int'(d), int'(fdat(4 * 1024 + 1023)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule